// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a byte-wide SPI master driven through a small word-addressed register bus. Software pushes bytes into a transmit FIFO through a data register. The shift engine sends each byte MSB first on `spi_mosi` and captures `spi_miso` into a receive FIFO in the same bit periods. Software pops the received bytes from a second data register.

A configuration register selects the clock polarity and phase and the SCLK rate, which is a power-of-two fraction of the core clock. It also selects how the chip-select pins are produced (engine-driven or software-forced, one-hot or binary index) and whether a transfer starts by itself or waits for a start command. A separate enable register gates the start of any transfer, and only a fresh enable loads new polarity and phase settings into the engine.

Register map (byte addresses): 0x00 configuration, 0x14 enable (bit 0), 0x1C transmit data (bits 7:0, write), 0x20 receive data (bits 7:0, read). Configuration bits: 0 master, 1 polarity, 2 phase, 5:3 rate exponent, 9 index decode, 13:10 select field, 14 forced select, 15 start-on-command, 16 start command.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, `spi_ss_n` is all ones and `spi_sclk` is 0. A read of configuration address 0x00 returns 0x00003C09 (master bit 0 set, rate exponent bits 5:3 = 1, select field bits 13:10 = 4'hF). A read of enable address 0x14 returns 0.
- R2: When no byte is shifting, SCLK rests at the active polarity level. Inside a byte the 16 SCLK edges are spaced (1 << n) core cycles apart, where n is configuration bits 5:3 and n = 0 acts as 1.
- R3: Bits leave MSB first. With phase (bit 2) at 0, MOSI is valid at the first edge of each bit and is sampled there. With phase at 1, MOSI changes at the first edge and is sampled at the second.
- R4: Every transmitted byte yields exactly one received byte, holding the MISO bits taken at the sampling edges. Received bytes come back in transmit order through address 0x20, bits 7:0.
- R5: A new byte starts only while enable bit 0 (address 0x14) and master bit 0 (address 0x00) are both 1. Bytes written while either is 0 wait in the transmit FIFO.
- R6: Polarity and phase written to the configuration register are used only after a write of 1 to enable bit 0 while that bit was 0.
- R7: With start-on-command (bit 15) set, queued bytes wait until a configuration write has bits 15 and 16 both set. That burst then runs until the transmit FIFO drains, and each later burst needs a new command. Bit 16 always reads back 0. With bit 15 clear, a byte starts as soon as one is queued.
- R8: With forced select (bit 14) clear, `spi_ss_n` carries the select pattern from the cycle the first byte of a burst is fetched until the burst ends. Between bursts it is all ones.
- R9: With forced select set and decode (bit 9) clear, `spi_ss_n` equals select field bits 13:10 whether or not a transfer is running.
- R10: With decode set, the select field is a binary index k. For k below the number of select lines, line k is driven low and the others high. Any larger k drives all lines high.
- R11: A read of 0x20 while the receive FIFO is empty returns 0 and does not change the FIFO contents.
- R12: A write to 0x1C while the transmit FIFO is full is dropped. A byte starts only when the receive FIFO has room for its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the SCLK reference |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SS | Active-low select lines |

## Verification
Read data lands on the clock edge that takes `reg_rd`. The bench therefore drives strobes on falling edges and samples one falling edge later. Select pins follow a configuration write two edges later, so the bench waits three cycles before it compares them. The first SCLK edge of a byte comes 1 + (1 << n) cycles after the transmit FIFO is popped. A monitor clocked on the falling edge measures the spacing of every later edge inside the byte against the rate setting, and rebuilds MOSI bytes at the edges the phase setting names. Transfer results are read only after a wait sized from the byte count and the rate, with margin.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 6;
  localparam int SS_FW   = 4;
  localparam int CFG_DIV_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN  = 6'h14;
  localparam logic [ADDR_W-1:0] A_TX  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_RX  = 6'h20;

  localparam int B_MSTR  = 0;
  localparam int B_CPOL  = 1;
  localparam int B_CPHA  = 2;
  localparam int B_DIV   = 3;
  localparam int B_DEC   = 9;
  localparam int B_SS    = 10;
  localparam int B_MANSS = 14;
  localparam int B_MSEN  = 15;
  localparam int B_MGO   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full,
  output logic         afull
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp, cnt;
  logic         do_push, do_pop;

  assign cnt     = wp - rp;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign afull   = (cnt >= (AW+1)'(DEPTH-1));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= push_data;
    if (do_pop)  pop_data <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt == (AW+1)'(DEPTH)));
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spim_shift.sv
module spim_shift import spim_pkg::*; #(
  parameter int W     = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             start_ok,
  input  logic             more_ok,
  input  logic [W-1:0]     tx_data,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [W-1:0]     rx_data,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             busy_next
);
  localparam int CNT_W = 1 << DIV_W;
  localparam int EW    = $clog2(2*W);

  eng_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, half_m1_q, half_m1;
  logic [EW-1:0]    edge_q;
  logic [W-1:0]     sh_q, rxsh_q;
  logic             sclk_q, tick, last, samp;
  logic [DIV_W-1:0] d_eff;

  assign d_eff   = (div == '0) ? DIV_W'(1) : div;
  assign half_m1 = ~({CNT_W{1'b1}} << d_eff);
  assign tick    = (state_q == ST_SHIFT) && (cnt_q == half_m1_q);
  assign last    = tick && (edge_q == EW'(2*W-1));
  assign samp    = (!edge_q[0]) ^ cpha;

  always_comb begin
    state_d = state_q;
    tx_pop  = 1'b0;
    case (state_q)
      ST_IDLE:  if (start_ok) begin tx_pop = 1'b1; state_d = ST_LOAD; end
      ST_LOAD:  state_d = ST_SHIFT;
      ST_SHIFT: if (last) begin
                  if (more_ok) begin tx_pop = 1'b1; state_d = ST_LOAD; end
                  else state_d = ST_IDLE;
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  assign rx_push   = last;
  assign rx_data   = cpha ? {rxsh_q[W-2:0], miso} : rxsh_q;
  assign busy      = (state_q != ST_IDLE);
  assign busy_next = (state_d != ST_IDLE);
  assign sclk      = sclk_q;
  assign mosi      = sh_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      half_m1_q <= '0;
      edge_q    <= '0;
      sh_q      <= '0;
      rxsh_q    <= '0;
      sclk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: sclk_q <= cpol;
        ST_LOAD: begin
          sh_q      <= tx_data;
          rxsh_q    <= '0;
          cnt_q     <= '0;
          edge_q    <= '0;
          half_m1_q <= half_m1;
          sclk_q    <= cpol;
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt_q  <= '0;
            edge_q <= edge_q + 1'b1;
            sclk_q <= ~sclk_q;
            if (samp) rxsh_q <= {rxsh_q[W-2:0], miso};
            else if (edge_q != '0) sh_q <= {sh_q[W-2:0], 1'b0};
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && $past(state_q) == ST_IDLE && $stable(cpol)) |-> (sclk == cpol));
  p_start_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD && $past(state_q) == ST_IDLE) |-> $past(start_ok));
  p_edge_parity_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && $past(state_q) == ST_LOAD) |-> (sclk == cpol));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs import spim_pkg::*; #(
  parameter int FIFO_DEPTH = 128,
  parameter int NUM_SS     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_SS-1:0] spi_ss_n
);
  localparam int W = BYTE_W;

  logic                 cfg_mstr, cfg_cpol, cfg_cpha, cfg_dec, cfg_manss, cfg_msen;
  logic [CFG_DIV_W-1:0] cfg_div;
  logic [SS_FW-1:0]     cfg_ss;
  logic                 en_q, cpol_act, cpha_act, start_pend;
  logic                 wr_cfg, wr_en, wr_tx, rd_rx;
  logic                 rsel_rx, rx_val;
  logic [31:0]          rdata_q, cfg_word;
  logic [NUM_SS-1:0]    dec_n, sel_n, ss_q;

  logic         tx_empty, unused_tx_full, unused_tx_afull;
  logic         rx_empty, rx_full, rx_afull;
  logic [W-1:0] tx_head, rx_head, eng_rx_data;
  logic         eng_pop, eng_rx_push, eng_busy, eng_busy_next, eng_start;
  logic         run, start_ok, more_ok;
  logic         unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:17], reg_wdata[8]};

  assign wr_cfg = reg_wr && (reg_addr == A_CFG);
  assign wr_en  = reg_wr && (reg_addr == A_EN);
  assign wr_tx  = reg_wr && (reg_addr == A_TX);
  assign rd_rx  = reg_rd && (reg_addr == A_RX);

  always_comb begin
    cfg_word = '0;
    cfg_word[B_MSTR] = cfg_mstr;
    cfg_word[B_CPOL] = cfg_cpol;
    cfg_word[B_CPHA] = cfg_cpha;
    cfg_word[B_DIV +: CFG_DIV_W] = cfg_div;
    cfg_word[B_DEC] = cfg_dec;
    cfg_word[B_SS +: SS_FW] = cfg_ss;
    cfg_word[B_MANSS] = cfg_manss;
    cfg_word[B_MSEN] = cfg_msen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mstr   <= 1'b1;
      cfg_cpol   <= 1'b0;
      cfg_cpha   <= 1'b0;
      cfg_div    <= CFG_DIV_W'(1);
      cfg_dec    <= 1'b0;
      cfg_ss     <= '1;
      cfg_manss  <= 1'b0;
      cfg_msen   <= 1'b0;
      en_q       <= 1'b0;
      cpol_act   <= 1'b0;
      cpha_act   <= 1'b0;
      start_pend <= 1'b0;
    end else begin
      if (eng_start) start_pend <= 1'b0;
      if (wr_cfg) begin
        cfg_mstr  <= reg_wdata[B_MSTR];
        cfg_cpol  <= reg_wdata[B_CPOL];
        cfg_cpha  <= reg_wdata[B_CPHA];
        cfg_div   <= reg_wdata[B_DIV +: CFG_DIV_W];
        cfg_dec   <= reg_wdata[B_DEC];
        cfg_ss    <= reg_wdata[B_SS +: SS_FW];
        cfg_manss <= reg_wdata[B_MANSS];
        cfg_msen  <= reg_wdata[B_MSEN];
        if (reg_wdata[B_MSEN] && reg_wdata[B_MGO]) start_pend <= 1'b1;
      end
      if (wr_en) begin
        en_q <= reg_wdata[0];
        if (reg_wdata[0] && !en_q) begin
          cpol_act <= cfg_cpol;
          cpha_act <= cfg_cpha;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_rx <= 1'b0;
      rx_val  <= 1'b0;
      rdata_q <= '0;
    end else if (reg_rd) begin
      rsel_rx <= (reg_addr == A_RX);
      rx_val  <= !rx_empty;
      case (reg_addr)
        A_CFG:   rdata_q <= cfg_word;
        A_EN:    rdata_q <= {31'b0, en_q};
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rsel_rx ? (rx_val ? {{(32-W){1'b0}}, rx_head} : 32'b0) : rdata_q;

  assign run      = en_q && cfg_mstr;
  assign start_ok = run && !tx_empty && !rx_full && (!cfg_msen || start_pend);
  assign more_ok  = run && !tx_empty && !rx_afull;
  assign eng_start = eng_pop && !eng_busy;

  spim_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_tx), .push_data(reg_wdata[W-1:0]),
    .pop(eng_pop), .pop_data(tx_head), .empty(tx_empty),
    .full(unused_tx_full), .afull(unused_tx_afull));

  spim_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rd_rx), .pop_data(rx_head), .empty(rx_empty),
    .full(rx_full), .afull(rx_afull));

  spim_shift #(.W(W), .DIV_W(CFG_DIV_W)) u_eng (
    .clk(clk), .rst(rst), .cpol(cpol_act), .cpha(cpha_act), .div(cfg_div),
    .start_ok(start_ok), .more_ok(more_ok), .tx_data(tx_head), .miso(spi_miso),
    .tx_pop(eng_pop), .rx_push(eng_rx_push), .rx_data(eng_rx_data),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy), .busy_next(eng_busy_next));

  for (genvar k = 0; k < NUM_SS; k++) begin : g_dec
    assign dec_n[k] = (cfg_ss != SS_FW'(k));
  end

  assign sel_n = cfg_dec ? dec_n : cfg_ss[NUM_SS-1:0];

  always_ff @(posedge clk) begin
    if (rst) ss_q <= '1;
    else     ss_q <= (cfg_manss || eng_busy_next) ? sel_n : '1;
  end
  assign spi_ss_n = ss_q;

  p_ss_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_manss) && !eng_busy) |-> (spi_ss_n == '1));
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !wr_cfg) |=> !start_pend);
  p_decode_one_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_manss) && $past(cfg_dec) && ($past(cfg_ss) < SS_FW'(NUM_SS)))
      |-> ($countones(~spi_ss_n) == 1));
endmodule

// File: tb/spi_master_regs_test.sv
module spi_master_regs_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_ss_n;
  logic        miso_inv = 1'b0;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errs = 0;

  always #2 clk = ~clk;
  assign spi_miso = spi_mosi ^ miso_inv;

  spi_master_regs #(.FIFO_DEPTH(DEPTH), .NUM_SS(4)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n));

  // monitor: bench-side SPI slave model
  logic       mon_on = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  int         exp_half = 2;
  logic       prev_sclk = 1'b0;
  int         gap = 0, eib = 0, bitcnt = 0, capn = 0;
  logic [7:0] capsh = '0;
  logic [7:0] cap [0:31];
  logic [3:0] ss_seen = 4'hF;

  always @(negedge clk) begin
    if (!mon_on) begin
      prev_sclk = spi_sclk; gap = 0; eib = 0; bitcnt = 0; capn = 0;
    end else begin
      gap = gap + 1;
      if (spi_sclk != prev_sclk) begin
        if (eib == 0) ss_seen = spi_ss_n;
        else begin
          mon_checks++;
          if (gap != exp_half) begin
            mon_errs++;
            $display("FAIL R2 edge spacing act=%0d exp=%0d", gap, exp_half);
          end
        end
        if ((prev_sclk == mon_cpol) ^ mon_cpha) begin
          capsh = {capsh[6:0], spi_mosi};
          bitcnt = bitcnt + 1;
          if (bitcnt == 8) begin
            if (capn < 32) cap[capn] = capsh;
            capn = capn + 1; bitcnt = 0;
          end
        end
        eib = (eib + 1) % 16; gap = 0; prev_sclk = spi_sclk;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_restart(input logic pol, input logic pha, input int half);
    mon_on = 1'b0; mon_cpol = pol; mon_cpha = pha; exp_half = half;
    idle(2); mon_on = 1'b1;
  endtask

  function automatic logic [31:0] cfgw(input logic mstr, input logic pol, input logic pha,
      input logic [2:0] dv, input logic dec, input logic [3:0] ss, input logic manss,
      input logic msen, input logic go);
    logic [31:0] w = '0;
    w[0] = mstr; w[1] = pol; w[2] = pha; w[5:3] = dv; w[9] = dec;
    w[13:10] = ss; w[14] = manss; w[15] = msen; w[16] = go;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b0, b1, inv;
    int          half;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 ss_n", {28'b0, spi_ss_n}, 32'hF);
    check("R1 sclk", {31'b0, spi_sclk}, 32'h0);
    rd(6'h00, d); check("R1 cfg", d, 32'h0000_3C09);
    rd(6'h14, d); check("R1 en", d, 32'h0);
    rd(6'h20, d); check("R11 empty rx", d, 32'h0);

    // R2 R3 R4 R8 R11 sweep over modes and rates
    for (int mode = 0; mode < 4; mode++) begin
      for (int dv = 0; dv < 4; dv++) begin
        half = 1 << ((dv == 0) ? 1 : dv);
        wr(6'h14, 0);
        wr(6'h00, cfgw(1, mode[1], mode[0], 3'(dv), 0, 4'b1110, 0, 0, 0));
        wr(6'h14, 1);
        idle(4);
        mon_restart(mode[1], mode[0], half);
        inv = ((mode + dv) % 2 == 1) ? 8'hFF : 8'h00;
        miso_inv = inv[0];
        b0 = 8'h5A ^ 8'(mode * 16 + dv * 3);
        b1 = {b0[3:0], b0[7:4]} ^ 8'h3C;
        wr(6'h1C, {24'b0, b0});
        wr(6'h1C, {24'b0, b1});
        idle(2 * (16 * half + 2) + 20);
        check("R3 count", capn, 2);
        check("R3 byte0 msb-first", {24'b0, cap[0]}, {24'b0, b0});
        check("R3 byte1 msb-first", {24'b0, cap[1]}, {24'b0, b1});
        check("R8 ss during burst", {28'b0, ss_seen}, 32'hE);
        check("R8 ss after burst", {28'b0, spi_ss_n}, 32'hF);
        check("R2 idle level", {31'b0, spi_sclk}, {31'b0, mode[1]});
        rd(6'h20, d); check("R4 rx0", d, {24'b0, b0 ^ inv});
        rd(6'h20, d); check("R4 rx1", d, {24'b0, b1 ^ inv});
        rd(6'h20, d); check("R11 drained", d, 32'h0);
      end
    end
    miso_inv = 1'b0;

    // R5 gating
    wr(6'h14, 0);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    wr(6'h14, 1);
    idle(4);
    mon_restart(0, 0, 2);
    wr(6'h14, 0);
    wr(6'h1C, 32'hC3);
    idle(200);
    check("R5 held while disabled", capn, 0);
    check("R5 ss idle while disabled", {28'b0, spi_ss_n}, 32'hF);
    wr(6'h14, 1);
    idle(100);
    check("R5 runs after enable", capn, 1);
    check("R5 byte", {24'b0, cap[0]}, 32'hC3);
    rd(6'h20, d);
    wr(6'h00, cfgw(0, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    wr(6'h1C, 32'h11);
    idle(100);
    check("R5 held with master off", capn, 1);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    idle(100);
    check("R5 runs with master on", capn, 2);
    rd(6'h20, d); check("R5 rx", d, 32'h11);

    // R6 polarity only at enable
    wr(6'h00, cfgw(1, 1, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    idle(10);
    check("R6 no change before enable", {31'b0, spi_sclk}, 32'h0);
    wr(6'h14, 0);
    wr(6'h14, 1);
    idle(3);
    check("R6 new level after enable", {31'b0, spi_sclk}, 32'h1);
    mon_restart(1, 0, 2);
    wr(6'h1C, 32'h96);
    idle(100);
    check("R6 byte in new mode", {24'b0, cap[0]}, 32'h96);
    rd(6'h20, d); check("R6 rx", d, 32'h96);
    wr(6'h14, 0);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1110, 0, 1, 0));
    wr(6'h14, 1);
    idle(4);

    // R7 manual start
    mon_restart(0, 0, 2);
    wr(6'h1C, 32'h3E);
    wr(6'h1C, 32'h7D);
    idle(150);
    check("R7 waits for command", capn, 0);
    check("R7 ss idle", {28'b0, spi_ss_n}, 32'hF);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1110, 0, 1, 1));
    idle(120);
    check("R7 burst count", capn, 2);
    check("R7 byte0", {24'b0, cap[0]}, 32'h3E);
    check("R7 byte1", {24'b0, cap[1]}, 32'h7D);
    rd(6'h00, d);
    check("R7 command reads 0", {31'b0, d[16]}, 32'h0);
    check("R7 enable bit kept", {31'b0, d[15]}, 32'h1);
    rd(6'h20, d); rd(6'h20, d);
    wr(6'h1C, 32'h44);
    idle(100);
    check("R7 new burst needs command", capn, 2);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    idle(60);
    check("R7 auto start", capn, 3);
    rd(6'h20, d); check("R7 rx", d, 32'h44);

    // R9 forced one-hot select
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b0110, 1, 0, 0));
    idle(3);
    check("R9 forced 0110", {28'b0, spi_ss_n}, 32'h6);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1001, 1, 0, 0));
    idle(3);
    check("R9 forced 1001", {28'b0, spi_ss_n}, 32'h9);

    // R10 decoded index sweep
    for (int k = 0; k < 16; k++) begin
      wr(6'h00, cfgw(1, 0, 0, 3'd1, 1, 4'(k), 1, 0, 0));
      idle(3);
      check("R10 decode", {28'b0, spi_ss_n}, (k < 4) ? {28'b0, ~(4'b1 << k)} : 32'hF);
    end
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 1, 4'd2, 0, 0, 0));
    idle(3);
    check("R10 auto idle", {28'b0, spi_ss_n}, 32'hF);
    mon_restart(0, 0, 2);
    wr(6'h1C, 32'h21);
    idle(100);
    check("R10 auto decoded", {28'b0, ss_seen}, 32'hB);
    rd(6'h20, d);

    // R12 full FIFOs
    wr(6'h14, 0);
    wr(6'h00, cfgw(1, 0, 0, 3'd1, 0, 4'b1110, 0, 0, 0));
    wr(6'h14, 1);
    idle(4);
    mon_restart(0, 0, 2);
    wr(6'h14, 0);
    for (int i = 0; i < 10; i++) wr(6'h1C, 32'(i * 17 + 1));
    wr(6'h14, 1);
    idle(400);
    check("R12 tx overflow dropped", capn, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      check("R12 kept byte", {24'b0, cap[i]}, 32'(i * 17 + 1));
    wr(6'h1C, 32'hEE);
    idle(100);
    check("R12 waits for rx room", capn, DEPTH);
    rd(6'h20, d); check("R12 rx first", d, 32'h1);
    idle(100);
    check("R12 resumes", capn, DEPTH + 1);
    check("R12 late byte", {24'b0, cap[DEPTH]}, 32'hEE);
    for (int i = 1; i < DEPTH; i++) begin
      rd(6'h20, d); check("R12 rx order", d, 32'(i * 17 + 1));
    end
    rd(6'h20, d); check("R12 rx late", d, 32'hEE);
    rd(6'h20, d); check("R11 empty again", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
    $finish;
  end
endmodule